// File: doc/BRIEF.md
# Split Row/Column DRAM Command Encoder

This block sits at the pin edge of a memory controller for one channel of a die-stacked DRAM. It turns abstract requests into the bit patterns of two narrow command buses. Each bus runs at double data rate, so it carries one half-word for the rising clock edge and another for the falling edge. Row requests (activate, precharge, precharge-all, per-bank refresh, all-bank refresh) are encoded onto a 6-bit bus. Column requests (read, write, mode-register write) are encoded onto an 8-bit bus. Each bus has its own valid/ready handshake. The two buses work independently, so a column access can go out in the same clock as a row activate.

An accepted request appears on the outputs in the clock after the handshake, as a registered rising/falling pair. Activate carries a 16-bit row address and therefore takes two clocks. The row interface refuses new requests while the first of those two clocks is on the bus. When nothing has been accepted, each bus drives its all-zero idle word. Every falling half includes an even-parity bit covering the whole clock's pattern.

Top module: `dcmd_encoder`

## Requirements
- R1: After reset, and in any clock whose row slot received no request, the row bus drives rise=000000 and fall=000000. After reset, and in any clock whose column slot received no request, the column bus drives rise=00000000 and fall=00000000. `row_ready` is high after reset, including after a reset that arrives in the middle of an activate.
- R2: Input codes on `row_cmd` are: 0 idle, 1 activate, 2 precharge, 3 precharge-all, 4 per-bank refresh, 5 all-bank refresh. An activate accepted at clock edge k drives two output clocks.
  - From edge k+1: rise = {11, bank}, fall = {p, row[15:11]}.
  - From edge k+2: rise = row[10:5], fall = {p, row[4:0]}.
- R3: `row_ready` is low exactly in the clock that shows the first half of an activate. A request offered in that clock is ignored and leaves no trace on the outputs. A request accepted in the following clock appears right after the second half of the activate.
- R4: Precharge drives rise = {10, bank}. Per-bank refresh drives rise = {01, bank}. For both, the falling payload bits [4:0] are zero.
- R5: Precharge-all drives rise = 000001 and all-bank refresh drives rise = 000010. Neither carries the bank input, and both have falling payload bits [4:0] equal to zero.
- R6: Codes on `col_cmd` are: 0 idle, 1 read, 2 write, 3 mode-register write. Read drives rise = {101, ap, bank} and write drives rise = {110, ap, bank}. For both, fall = {p, 00, col[4:0]}.
- R7: Mode-register write drives rise = {111, 0, index} and fall = {p, data[6:0]}. The register index is taken from `col_bank`.
- R8: Every clock, the parity bit makes the number of ones across that bus's rising and falling half-words even. The parity bit sits in bit 5 of `row_fall` and in bit 7 of `col_fall`.
- R9: `col_ready` is always high outside reset. A column request is encoded in the same clock as either half of a row activate, with no effect on either bus.
- R10: Row codes 6 and 7 are accepted and produce the row idle pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_valid | input | 1 | Row request offered |
| row_ready | output | 1 | Row request can be taken this clock |
| row_cmd | input | 3 | Row request code |
| row_bank | input | BANK_W | Target bank |
| row_addr | input | 16 | Row address for activate |
| row_rise | output | BANK_W+2 | Row bus rising-edge half-word |
| row_fall | output | BANK_W+2 | Row bus falling-edge half-word |
| col_valid | input | 1 | Column request offered |
| col_ready | output | 1 | Column request can be taken this clock |
| col_cmd | input | 2 | Column request code |
| col_ap | input | 1 | Auto-precharge flag for read/write |
| col_bank | input | BANK_W | Bank, or register index for mode write |
| col_addr | input | COL_W | Column address |
| col_mr_data | input | BANK_W+3 | Mode register payload |
| col_rise | output | BANK_W+4 | Column bus rising-edge half-word |
| col_fall | output | BANK_W+4 | Column bus falling-edge half-word |

## Verification
The bench builds the block with its defaults, BANK_W=4 and COL_W=5. This gives the 6-bit row bus, the 8-bit column bus and the 16-bit row address split 5/6/5. With these widths, the bench can check the exact half-word values for all-ones and all-zeros banks, addresses and register data. It can also check the back-to-back activates, the ignored request during an activate, and column traffic overlapping both halves of an activate.

// File: rtl/dcmd_pkg.sv
`timescale 1ns/1ps
package dcmd_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE  = 3'd0,
    RQ_ACT   = 3'd1,
    RQ_PRE   = 3'd2,
    RQ_PREA  = 3'd3,
    RQ_REFSB = 3'd4,
    RQ_REF   = 3'd5
  } row_req_e;

  typedef enum logic [1:0] {
    CQ_IDLE = 2'd0,
    CQ_RD   = 2'd1,
    CQ_WR   = 2'd2,
    CQ_MRS  = 2'd3
  } col_req_e;

  // row bus opcode in the top two rising bits
  localparam logic [1:0] ROP_ACT   = 2'b11;
  localparam logic [1:0] ROP_PRE   = 2'b10;
  localparam logic [1:0] ROP_REFSB = 2'b01;
  localparam logic [1:0] ROP_GROUP = 2'b00;
  localparam int         SUB_PREA  = 1;
  localparam int         SUB_REF   = 2;

  // column bus opcode in the top three rising bits
  localparam logic [2:0] COP_RD  = 3'b101;
  localparam logic [2:0] COP_WR  = 3'b110;
  localparam logic [2:0] COP_MRS = 3'b111;

  // even parity over up to 32 command bits
  function automatic logic even_fill(input logic [31:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/dcmd_row_enc.sv
`timescale 1ns/1ps
module dcmd_row_enc #(
  parameter int BANK_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2:0]                    req_code,
  input  logic [BANK_W-1:0]             req_bank,
  input  logic [3*(BANK_W+2)-3:0]       req_row,
  output logic [BANK_W+1:0]             bus_rise,
  output logic [BANK_W+1:0]             bus_fall,
  output logic                          take,
  output logic                          act_tail
);
  import dcmd_pkg::*;

  localparam int BUS_W  = BANK_W + 2;
  localparam int HI_W   = BUS_W - 1;
  localparam int MID_W  = BUS_W;
  localparam int LO_W   = BUS_W - 1;
  localparam int ADDR_W = HI_W + MID_W + LO_W;
  localparam int TAIL_W = MID_W + LO_W;

  logic              tail_q;
  logic [TAIL_W-1:0] tail_row_q;
  logic [BUS_W-1:0]  rise_q, fall_q;
  logic [BUS_W-1:0]  nxt_rise;
  logic [HI_W-1:0]   nxt_pay;
  logic              nxt_tail;
  logic              is_act;

  function automatic logic [BUS_W-1:0] seal(input logic [BUS_W-1:0] r,
                                            input logic [HI_W-1:0] p);
    return {even_fill(32'({r, p})), p};
  endfunction

  assign req_ready = !tail_q;
  assign take      = req_valid && !tail_q;
  assign is_act    = take && (req_code == RQ_ACT);
  assign act_tail  = tail_q;

  always_comb begin
    nxt_rise = '0;
    nxt_pay  = '0;
    nxt_tail = 1'b0;
    if (tail_q) begin
      nxt_rise = tail_row_q[TAIL_W-1:LO_W];
      nxt_pay  = tail_row_q[LO_W-1:0];
    end else if (take) begin
      case (req_code)
        RQ_ACT: begin
          nxt_rise = {ROP_ACT, req_bank};
          nxt_pay  = req_row[ADDR_W-1 -: HI_W];
          nxt_tail = 1'b1;
        end
        RQ_PRE:   nxt_rise = {ROP_PRE, req_bank};
        RQ_REFSB: nxt_rise = {ROP_REFSB, req_bank};
        RQ_PREA:  nxt_rise = {ROP_GROUP, BANK_W'(SUB_PREA)};
        RQ_REF:   nxt_rise = {ROP_GROUP, BANK_W'(SUB_REF)};
        default:  nxt_rise = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q     <= 1'b0;
      tail_row_q <= '0;
      rise_q     <= '0;
      fall_q     <= '0;
    end else begin
      tail_q <= nxt_tail;
      if (is_act) tail_row_q <= req_row[TAIL_W-1:0];
      rise_q <= nxt_rise;
      fall_q <= seal(nxt_rise, nxt_pay);
    end
  end

  assign bus_rise = rise_q;
  assign bus_fall = fall_q;
endmodule

// File: rtl/dcmd_col_enc.sv
`timescale 1ns/1ps
module dcmd_col_enc #(
  parameter int BANK_W = 4,
  parameter int COL_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_code,
  input  logic                req_ap,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [COL_W-1:0]    req_col,
  input  logic [BANK_W+2:0]   req_mr_data,
  output logic [BANK_W+3:0]   bus_rise,
  output logic [BANK_W+3:0]   bus_fall,
  output logic                take
);
  import dcmd_pkg::*;

  localparam int BUS_W = BANK_W + 4;
  localparam int PAY_W = BUS_W - 1;

  logic [BUS_W-1:0] rise_q, fall_q;
  logic [BUS_W-1:0] nxt_rise;
  logic [PAY_W-1:0] nxt_pay;

  function automatic logic [BUS_W-1:0] seal(input logic [BUS_W-1:0] r,
                                            input logic [PAY_W-1:0] p);
    return {even_fill(32'({r, p})), p};
  endfunction

  assign req_ready = !rst;
  assign take      = req_valid && req_ready;

  always_comb begin
    nxt_rise = '0;
    nxt_pay  = '0;
    if (take) begin
      case (req_code)
        CQ_RD: begin
          nxt_rise = {COP_RD, req_ap, req_bank};
          nxt_pay  = PAY_W'(req_col);
        end
        CQ_WR: begin
          nxt_rise = {COP_WR, req_ap, req_bank};
          nxt_pay  = PAY_W'(req_col);
        end
        CQ_MRS: begin
          nxt_rise = {COP_MRS, 1'b0, req_bank};
          nxt_pay  = req_mr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= nxt_rise;
      fall_q <= seal(nxt_rise, nxt_pay);
    end
  end

  assign bus_rise = rise_q;
  assign bus_fall = fall_q;
endmodule

// File: rtl/dcmd_encoder.sv
`timescale 1ns/1ps
module dcmd_encoder #(
  parameter int BANK_W = 4,
  parameter int COL_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      row_valid,
  output logic                      row_ready,
  input  logic [2:0]                row_cmd,
  input  logic [BANK_W-1:0]         row_bank,
  input  logic [3*(BANK_W+2)-3:0]   row_addr,
  output logic [BANK_W+1:0]         row_rise,
  output logic [BANK_W+1:0]         row_fall,
  input  logic                      col_valid,
  output logic                      col_ready,
  input  logic [1:0]                col_cmd,
  input  logic                      col_ap,
  input  logic [BANK_W-1:0]         col_bank,
  input  logic [COL_W-1:0]          col_addr,
  input  logic [BANK_W+2:0]         col_mr_data,
  output logic [BANK_W+3:0]         col_rise,
  output logic [BANK_W+3:0]         col_fall
);
  // named internal events for the checker
  logic row_take;
  logic row_act_tail;
  logic col_take;

  dcmd_row_enc #(.BANK_W(BANK_W)) u_row (
    .clk(clk), .rst(rst),
    .req_valid(row_valid), .req_ready(row_ready),
    .req_code(row_cmd), .req_bank(row_bank), .req_row(row_addr),
    .bus_rise(row_rise), .bus_fall(row_fall),
    .take(row_take), .act_tail(row_act_tail)
  );

  dcmd_col_enc #(.BANK_W(BANK_W), .COL_W(COL_W)) u_col (
    .clk(clk), .rst(rst),
    .req_valid(col_valid), .req_ready(col_ready),
    .req_code(col_cmd), .req_ap(col_ap), .req_bank(col_bank),
    .req_col(col_addr), .req_mr_data(col_mr_data),
    .bus_rise(col_rise), .bus_fall(col_fall),
    .take(col_take)
  );
endmodule

// File: rtl/dcmd_encoder_chk.sv
`timescale 1ns/1ps
module dcmd_encoder_chk #(
  parameter int BANK_W = 4,
  parameter int COL_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    row_valid,
  input logic                    row_ready,
  input logic [2:0]              row_cmd,
  input logic [3*(BANK_W+2)-3:0] row_addr,
  input logic [BANK_W+1:0]       row_rise,
  input logic [BANK_W+1:0]       row_fall,
  input logic                    row_act_tail,
  input logic                    col_valid,
  input logic                    col_ready,
  input logic [1:0]              col_cmd,
  input logic [BANK_W+3:0]       col_rise,
  input logic [BANK_W+3:0]       col_fall
);
  localparam int RB = BANK_W + 2;
  localparam int CB = BANK_W + 4;
  localparam int LO = RB - 1;

  AST_ROW_EVEN: assert property (@(posedge clk) disable iff (rst)
    ^{row_rise, row_fall} == 1'b0);                                         // R8
  AST_COL_EVEN: assert property (@(posedge clk) disable iff (rst)
    ^{col_rise, col_fall} == 1'b0);                                         // R8
  AST_ACT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_ready && row_cmd == 3'd1) |=> (!row_ready && row_act_tail)); // R3
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
    !row_ready |=> row_ready);                                              // R3
  AST_ACT_MID: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_ready && row_cmd == 3'd1) |=> ##1
      (row_rise == $past(row_addr[LO+RB-1:LO], 2)));                        // R2
  AST_ROW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!row_valid && row_ready) |=> (row_rise == '0 && row_fall == '0));      // R1
  AST_COL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !col_valid |=> (col_rise == '0 && col_fall == '0));                     // R1
  AST_COL_READ: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_cmd == 2'd1) |=> (col_rise[CB-1 -: 3] == 3'b101));    // R6
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_ready && row_cmd >= 3'd6) |=>
      (row_rise == '0 && row_fall == '0));                                  // R10
  AST_COL_OPEN: assert property (@(posedge clk) disable iff (rst)
    (row_act_tail || !row_ready) |-> col_ready);                            // R9
endmodule

bind dcmd_encoder dcmd_encoder_chk #(.BANK_W(BANK_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst),
  .row_valid(row_valid), .row_ready(row_ready), .row_cmd(row_cmd),
  .row_addr(row_addr), .row_rise(row_rise), .row_fall(row_fall),
  .row_act_tail(row_act_tail),
  .col_valid(col_valid), .col_ready(col_ready), .col_cmd(col_cmd),
  .col_rise(col_rise), .col_fall(col_fall)
);

// File: tb/tb_dcmd_encoder.sv
`timescale 1ns/1ps
module tb_dcmd_encoder;
  localparam int BANK_W = 4;
  localparam int COL_W  = 5;

  typedef struct packed {
    logic        rv;
    logic [2:0]  rc;
    logic [3:0]  rb;
    logic [15:0] ra;
    logic        cv;
    logic [1:0]  cc;
    logic        cap;
    logic [3:0]  cb;
    logic [4:0]  ca;
    logic [6:0]  cd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 4'd0,  16'h0000, 1'b0, 2'd0, 1'b0, 4'd0,  5'd0,  7'h00},
    '{1'b1, 3'd1, 4'd5,  16'hA5C3, 1'b1, 2'd1, 1'b1, 4'd3,  5'd17, 7'h00},
    '{1'b1, 3'd2, 4'd2,  16'h0000, 1'b1, 2'd2, 1'b0, 4'd9,  5'd31, 7'h00},
    '{1'b1, 3'd2, 4'd2,  16'h0000, 1'b1, 2'd3, 1'b0, 4'd6,  5'd0,  7'h5A},
    '{1'b1, 3'd4, 4'd15, 16'h0000, 1'b0, 2'd0, 1'b0, 4'd0,  5'd0,  7'h00},
    '{1'b1, 3'd3, 4'd7,  16'h0000, 1'b1, 2'd1, 1'b0, 4'd12, 5'd1,  7'h00},
    '{1'b1, 3'd5, 4'd3,  16'h0000, 1'b1, 2'd0, 1'b1, 4'd5,  5'd3,  7'h11},
    '{1'b1, 3'd1, 4'd0,  16'hFFFF, 1'b1, 2'd3, 1'b0, 4'd15, 5'd0,  7'h7F},
    '{1'b1, 3'd1, 4'd10, 16'h0001, 1'b1, 2'd1, 1'b0, 4'd1,  5'd2,  7'h00},
    '{1'b1, 3'd1, 4'd10, 16'h8421, 1'b1, 2'd2, 1'b1, 4'd0,  5'd8,  7'h00},
    '{1'b1, 3'd6, 4'd9,  16'h1234, 1'b1, 2'd2, 1'b1, 4'd8,  5'd16, 7'h00},
    '{1'b1, 3'd7, 4'd4,  16'hFFFF, 1'b0, 2'd1, 1'b0, 4'd0,  5'd0,  7'h00},
    '{1'b0, 3'd0, 4'd0,  16'h0000, 1'b0, 2'd0, 1'b0, 4'd0,  5'd0,  7'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_valid = 1'b0;
  logic        row_ready;
  logic [2:0]  row_cmd = '0;
  logic [3:0]  row_bank = '0;
  logic [15:0] row_addr = '0;
  logic [5:0]  row_rise, row_fall;
  logic        col_valid = 1'b0;
  logic        col_ready;
  logic [1:0]  col_cmd = '0;
  logic        col_ap = 1'b0;
  logic [3:0]  col_bank = '0;
  logic [4:0]  col_addr = '0;
  logic [6:0]  col_mr_data = '0;
  logic [7:0]  col_rise, col_fall;

  dcmd_encoder #(.BANK_W(BANK_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst(rst),
    .row_valid(row_valid), .row_ready(row_ready), .row_cmd(row_cmd),
    .row_bank(row_bank), .row_addr(row_addr),
    .row_rise(row_rise), .row_fall(row_fall),
    .col_valid(col_valid), .col_ready(col_ready), .col_cmd(col_cmd),
    .col_ap(col_ap), .col_bank(col_bank), .col_addr(col_addr),
    .col_mr_data(col_mr_data), .col_rise(col_rise), .col_fall(col_fall)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model
  bit          m_tail = 1'b0;
  logic [10:0] m_tail_row = '0;
  bit          have_exp = 1'b0;
  logic [5:0]  e_rr, e_rf;
  logic [7:0]  e_cr, e_cf;
  string       e_rtag, e_ctag;

  function automatic logic odd_ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_out();
    check({row_rise, row_fall} == {e_rr, e_rf}, e_rtag,
          32'({row_rise, row_fall}), 32'({e_rr, e_rf}));
    check({col_rise, col_fall} == {e_cr, e_cf}, e_ctag,
          32'({col_rise, col_fall}), 32'({e_cr, e_cf}));
    check(!odd_ones(16'({row_rise, row_fall})) && !odd_ones({col_rise, col_fall}),
          "R8 parity", 32'({row_rise, row_fall, col_rise, col_fall}), 32'h0);
  endtask

  task automatic predict(input vec_t v);
    logic [4:0] rp;
    logic [6:0] cp;
    bit act_busy;
    rp = '0; cp = '0; e_rr = '0; e_cr = '0;
    e_rtag = "R1 row idle"; e_ctag = "R1 col idle";
    act_busy = m_tail || (v.rv && v.rc == 3'd1);
    if (m_tail) begin
      e_rr = m_tail_row[10:5]; rp = m_tail_row[4:0];
      e_rtag = "R2 act second half"; m_tail = 1'b0;
    end else if (v.rv) begin
      case (v.rc)
        3'd1: begin
          e_rr = {2'b11, v.rb}; rp = v.ra[15:11];
          m_tail = 1'b1; m_tail_row = v.ra[10:0];
          e_rtag = "R2 act first half";
        end
        3'd2: begin e_rr = {2'b10, v.rb}; e_rtag = "R4 precharge"; end
        3'd4: begin e_rr = {2'b01, v.rb}; e_rtag = "R4 bank refresh"; end
        3'd3: begin e_rr = 6'b000001; e_rtag = "R5 precharge all"; end
        3'd5: begin e_rr = 6'b000010; e_rtag = "R5 refresh all"; end
        3'd0: e_rtag = "R1 row idle";
        default: e_rtag = "R10 bad row code";
      endcase
    end
    e_rf = {odd_ones(16'({e_rr, rp})), rp};
    if (v.cv) begin
      case (v.cc)
        2'd1: begin e_cr = {3'b101, v.cap, v.cb}; cp = {2'b00, v.ca}; e_ctag = "R6 read"; end
        2'd2: begin e_cr = {3'b110, v.cap, v.cb}; cp = {2'b00, v.ca}; e_ctag = "R6 write"; end
        2'd3: begin e_cr = {3'b111, 1'b0, v.cb}; cp = v.cd; e_ctag = "R7 mode write"; end
        default: e_ctag = "R1 col idle";
      endcase
      if (act_busy && v.cc != 2'd0) e_ctag = {e_ctag, " R9 beside act"};
    end
    e_cf = {odd_ones(16'({e_cr, cp})), cp};
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    if (have_exp) compare_out();
    check(row_ready == !m_tail, "R3 row_ready", 32'(row_ready), 32'(!m_tail));
    check(col_ready == 1'b1, "R9 col_ready", 32'(col_ready), 32'h1);
    row_valid = v.rv; row_cmd = v.rc; row_bank = v.rb; row_addr = v.ra;
    col_valid = v.cv; col_cmd = v.cc; col_ap = v.cap; col_bank = v.cb;
    col_addr = v.ca; col_mr_data = v.cd;
    predict(v);
    have_exp = 1'b1;
  endtask

  initial begin
    vec_t idle;
    vec_t act;
    idle = TBL[0];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({row_rise, row_fall, col_rise, col_fall} == '0, "R1 reset outputs",
          32'({row_rise, row_fall, col_rise, col_fall}), 32'h0);
    check(row_ready == 1'b1, "R1 reset ready", 32'(row_ready), 32'h1);

    for (int i = 0; i < NV; i++) step(TBL[i]);
    step(idle);

    // reset while the first half of an activate is on the bus
    act = TBL[1];
    step(act);
    @(negedge clk);
    compare_out();
    check(row_ready == 1'b0, "R3 ready low in act", 32'(row_ready), 32'h0);
    rst = 1'b1;
    row_valid = 1'b0; col_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_tail = 1'b0; have_exp = 1'b0;
    check({row_rise, row_fall, col_rise, col_fall} == '0, "R1 reset mid act",
          32'({row_rise, row_fall, col_rise, col_fall}), 32'h0);
    check(row_ready == 1'b1, "R1 ready after reset", 32'(row_ready), 32'h1);
    step(idle);
    step(TBL[3]);
    step(idle);
    step(idle);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not end actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule